// File: doc/BRIEF.md
# Read-Training Burst Aligner

This block sits on the slow side of a 4:1 deserializing DDR3 physical layer while the memory is in its read-training mode. Every slow clock it takes one 128-bit word. The word holds eight serial samples from each of the 16 data pins, so it carries one burst's worth of bus beats. A request strobe tells the block that a read has just been issued. From that point the block looks for the fixed training burst at every beat position inside a two-word window, made of the previous word and the current one. Because the read latency in fast cycles is odd, the burst can start anywhere inside a slow word and can straddle two words.

When it finds the burst, the block emits the realigned 128-bit burst with a one-cycle valid strobe. It reports the beat offset at which the burst started, a 2-bit suggestion for which of the four command slots should carry the read command, and a coarse delay counted in slow cycles. It declares lock after several consecutive reads agree on the offset. It raises an error when a request goes unanswered for too long.

Top module: `rl_aligner`

## Requirements
- R1: After reset, `dout_vld`, `lock`, `err`, `ofs`, `slot`, `coarse` and `dout` are all zero.
- R2: Beat k of a word is `din[16k+15:16k]`, and beat 0 is the earliest. The training burst is 8 beats that alternate 0x0000 (even beats) and 0xFFFF (odd beats). While a search is armed, the first edge at which the whole burst is present in {current word, previous word} makes `dout_vld` high for exactly the next cycle, with `dout` holding the 8 burst beats in order, beat 0 in the low bits.
- R3: If the burst starts at beat s of a word, the reported `ofs` is s for s = 1..7, and 8 for s = 0 (the burst lies wholly in the newer word).
- R4: `slot` equals `ofs` modulo 4.
- R5: A request is sampled at a clock edge. The words sampled at the following edges are numbered 0, 1, 2, and so on. `coarse` is the number of the word that holds the burst's final beat.
- R6: If no match occurs on any of the 16 words after a request, `err` goes high after the 16th of those edges. It stays high and no `dout_vld` is produced.
- R7: `lock` goes high once 4 consecutive matched reads report the same `ofs`. A match with a different `ofs` restarts the count at one. A timeout clears both the count and `lock`.
- R8: Data that contains the training burst but arrives with no request outstanding produces no `dout_vld` and leaves `err` unchanged.
- R9: A new request clears `err` at the edge that samples it, and it restarts the search window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (divided) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read issued; arms the search |
| din | input | 128 | Deserialized word: 8 beats of 16 bits |
| dout | output | 128 | Realigned burst |
| dout_vld | output | 1 | One-cycle strobe for `dout` and the reports |
| lock | output | 1 | Offset has been stable over 4 reads |
| err | output | 1 | Search timed out |
| ofs | output | 4 | Detected beat offset (1..8) |
| slot | output | 2 | Suggested command slot |
| coarse | output | 4 | Slow-cycle delay to the final beat |

## Verification
Some properties are checked on every cycle. Whenever the strobe is high, the emitted data must be the training pattern and the offset must lie between 1 and 8. An error never coincides with a strobe or with lock. Lock can only rise together with a match. The edge after a request always shows the error cleared. Other behaviour depends on a particular stimulus history, so only the bench scenarios can show it: the exact offset, slot and coarse count for each burst position and gap, lock being reached after exactly four agreeing reads and lost on a changed offset, the timeout landing on the sixteenth word, and pattern data being ignored while no request is outstanding.

// File: rtl/rl_aligner.sv
module rl_aligner #(
  parameter int DQ_W    = 16,
  parameter int BEATS   = 8,
  parameter int LOCK_N  = 4,
  parameter int TIMEOUT = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [DQ_W*BEATS-1:0]       din,
  output logic [DQ_W*BEATS-1:0]       dout,
  output logic                        dout_vld,
  output logic                        lock,
  output logic                        err,
  output logic [$clog2(BEATS+1)-1:0]  ofs,
  output logic [1:0]                  slot,
  output logic [$clog2(TIMEOUT)-1:0]  coarse
);
  localparam int W  = DQ_W * BEATS;
  localparam int OW = $clog2(BEATS + 1);
  localparam int CW = $clog2(TIMEOUT);
  localparam int RW = $clog2(LOCK_N + 1);

  function automatic logic [W-1:0] train_pat();
    logic [W-1:0] p;
    for (int b = 0; b < BEATS; b++) p[b*DQ_W +: DQ_W] = b[0] ? '1 : '0;
    return p;
  endfunction
  localparam logic [W-1:0] PAT = train_pat();

  logic [W-1:0]   prev;
  logic [2*W-1:0] win;
  logic [BEATS:0] m;
  logic           hit, armed;
  logic [OW-1:0]  hit_ofs;
  logic [W-1:0]   hit_dat;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  run;

  assign win = {din, prev};

  for (genvar g = 0; g <= BEATS; g++) begin : g_cmp
    assign m[g] = (win[g*DQ_W +: W] == PAT);
  end

  always_comb begin
    hit_ofs = '0;
    hit_dat = '0;
    for (int o = BEATS; o >= 0; o--)
      if (m[o]) begin
        hit_ofs = OW'(o);
        hit_dat = win[o*DQ_W +: W];
      end
  end
  assign hit = |m;

  assign slot = ofs[1:0];
  assign lock = (run == RW'(LOCK_N));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      err      <= 1'b0;
      dout_vld <= 1'b0;
      dout     <= '0;
      ofs      <= '0;
      coarse   <= '0;
      run      <= '0;
    end else begin
      dout_vld <= 1'b0;
      if (rd_req) begin
        armed <= 1'b1;
        cnt   <= '0;
        err   <= 1'b0;
      end else if (armed) begin
        if (hit) begin
          armed    <= 1'b0;
          dout_vld <= 1'b1;
          dout     <= hit_dat;
          ofs      <= hit_ofs;
          coarse   <= cnt;
          if (hit_ofs == ofs && run != '0)
            run <= lock ? run : run + 1'b1;
          else
            run <= RW'(1);
        end else if (cnt == CW'(TIMEOUT - 1)) begin
          armed <= 1'b0;
          err   <= 1'b1;
          run   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module rl_aligner_chk #(
  parameter int DQ_W  = 16,
  parameter int BEATS = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_req,
  input logic [DQ_W*BEATS-1:0]      dout,
  input logic                       dout_vld,
  input logic                       lock,
  input logic                       err,
  input logic [$clog2(BEATS+1)-1:0] ofs
);
  localparam int W = DQ_W * BEATS;

  function automatic logic [W-1:0] ref_pat();
    logic [W-1:0] p;
    for (int b = 0; b < BEATS; b++) p[b*DQ_W +: DQ_W] = b[0] ? '1 : '0;
    return p;
  endfunction

  assert_burst_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> dout == ref_pat());
  assert_ofs_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> (ofs != 0 && ofs <= ($clog2(BEATS+1))'(BEATS)));
  assert_err_no_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !dout_vld);
  assert_err_no_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !lock);
  assert_lock_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> dout_vld);
  assert_req_clears_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !err);
endmodule

bind rl_aligner rl_aligner_chk #(.DQ_W(DQ_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .dout(dout), .dout_vld(dout_vld),
  .lock(lock), .err(err), .ofs(ofs)
);

// File: tb/sim_rl_aligner.sv
module sim_rl_aligner;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_req = 1'b0;
  logic [127:0] din = '0;
  logic [127:0] dout;
  logic         dout_vld, lock, err;
  logic [3:0]   ofs, coarse;
  logic [1:0]   slot;
  int checks = 0, fails = 0;

  localparam logic [127:0] PAT = {4{32'hFFFF_0000}};
  // {start beat, idle gap, expected ofs, expected coarse}
  localparam logic [15:0] VEC [8] = '{16'h3031, 16'h0282, 16'h5152, 16'h7374,
                                      16'h1011, 16'h2526, 16'h6263, 16'h4041};

  rl_aligner u0 (.clk(clk), .rst_n(rst_n), .rd_req(rd_req), .din(din), .dout(dout),
    .dout_vld(dout_vld), .lock(lock), .err(err), .ofs(ofs), .slot(slot), .coarse(coarse));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] word(input int j, input int gap, input int s);
    logic [127:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      if (j == gap && k >= s) w[k*16 +: 16] = ((k - s) % 2) ? 16'hFFFF : 16'h0000;
      if (j == gap + 1 && s != 0 && k < s) w[k*16 +: 16] = ((8 - s + k) % 2) ? 16'hFFFF : 16'h0000;
    end
    return w;
  endfunction

  task automatic do_read(input int s, input int gap, input logic req,
                         input logic [3:0] eofs, input logic [3:0] ecoarse);
    int fin;
    fin = gap + (s != 0 ? 1 : 0);
    @(negedge clk); rd_req = req; din = '0;
    @(negedge clk); rd_req = 1'b0;
    for (int j = 0; j < gap + 4; j++) begin
      din = word(j, gap, s);
      @(negedge clk);
      if (!req) chk("R8 no strobe without request", dout_vld, 1'b0);
      else begin
        chk("R2 strobe timing", dout_vld, j == fin);
        if (j == fin) begin
          chk("R2 realigned burst", dout, PAT);
          chk("R3 offset", ofs, eofs);
          chk("R4 slot", slot, eofs[1:0]);
          chk("R5 coarse delay", coarse, ecoarse);
        end
      end
    end
    din = '0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 dout_vld", dout_vld, 0); chk("R1 lock", lock, 0); chk("R1 err", err, 0);
    chk("R1 ofs", ofs, 0); chk("R1 slot", slot, 0); chk("R1 coarse", coarse, 0);
    chk("R1 dout", dout, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      do_read(int'(VEC[v][15:12]), int'(VEC[v][11:8]), 1'b1, VEC[v][7:4], VEC[v][3:0]);
      chk("R7 no lock on varying offsets", lock, 0);
    end

    // R7 lock after four agreeing reads
    for (int r = 0; r < 4; r++) begin
      do_read(2, 1, 1'b1, 4'd2, 4'd2);
      chk("R7 lock count", lock, r == 3);
    end
    do_read(3, 0, 1'b1, 4'd3, 4'd1);
    chk("R7 lock lost on offset change", lock, 0);
    for (int r = 0; r < 3; r++) do_read(3, 0, 1'b1, 4'd3, 4'd1);
    chk("R7 relock", lock, 1);

    // R6 timeout
    @(negedge clk); rd_req = 1'b1; din = '0;
    @(negedge clk); rd_req = 1'b0;
    for (int j = 0; j < 19; j++) begin
      @(negedge clk);
      chk("R6 err timing", err, j >= 15);
      chk("R6 no strobe", dout_vld, 0);
    end
    chk("R7 timeout clears lock", lock, 0);

    // R8 unrequested pattern
    do_read(5, 1, 1'b0, 4'd0, 4'd0);
    chk("R8 err unchanged", err, 1);
    chk("R8 ofs unchanged", ofs, 3);

    // R9 request clears err
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk("R9 err cleared", err, 0);
    do_read(6, 0, 1'b1, 4'd6, 4'd1);
    chk("R7 count restarted after timeout", lock, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule